// File: doc/BRIEF.md
# Dual UART Baud Tick Selector

This block produces the baud clock enables for two independent UART channels. Each channel normally takes its rate from an external tick input, which usually comes from a timer-based generator elsewhere in the chip. A small control register holds one override bit per channel. When a channel's bit is set, its tick instead comes from a fixed internal reference of about 3.69 MHz divided by sixteen. A per-channel double-rate input then selects roughly 230 kbaud when high and 115 kbaud when low.

The reference arrives as a one-cycle enable pulse. One divide-by-sixteen counter, shared by both channels, turns that pulse into a fast tick. Each channel derives its slow tick by keeping every second fast tick.

A switch of source or rate never produces a shortened baud period. A new control bit or flag value is adopted only after the channel's current source has delivered its next tick, and that tick still comes from the old source.

Software reaches the register through a synchronous bus with a select, a write enable, an address and registered read data. The register answers at one parameterised address.

Top module: `dual_baud_sel`

## Requirements
- R1: A bus cycle with `bus_sel` and `bus_we` high and `bus_addr` equal to `REG_ADDR` loads bit 0 (channel 0 override) and bit 1 (channel 1 override) from `bus_wdata`. Writes to any other address leave the register unchanged.
- R2: A read at `REG_ADDR` returns the two override bits in `bus_rdata[1:0]`, with bits 7 to 2 always 0. The data appears on the clock edge after the read strobe. Reads of other addresses, and idle cycles, return 0.
- R3: After reset both override bits are 0 and both channels follow their normal tick inputs.
- R4: The shared divider emits exactly one fast tick for every 16 pulses of `ref_tick`, one cycle after the sixteenth pulse.
- R5: With a channel's override active, a high double-rate flag gives one baud tick per fast tick. A low flag gives one baud tick per two fast ticks.
- R6: With a channel's override inactive and settled, `baud_tick[i]` equals `norm_tick[i]` in the same cycle.
- R7: The two channels are independent. Each uses only its own override bit, its own `dbl_rate` bit and its own normal tick.
- R8: A change of a channel's override bit or double-rate flag is adopted only in the cycle after that channel's next output tick, and that tick still comes from the old source and rate.
- R9: Every baud tick produced from the reference lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ref_tick | input | 1 | Enable pulse of the fixed internal reference |
| dbl_rate | input | NUM_CH | Per-channel double-rate flag |
| norm_tick | input | NUM_CH | Per-channel normal baud tick |
| baud_tick | output | NUM_CH | Per-channel selected baud tick |

## Verification
Some properties are checked on every cycle:
- the reserved read bits stay zero;
- the register changes only after an addressed write;
- the fast tick arrives after exactly sixteen reference pulses;
- a reference-driven output tick coincides with a fast tick and is a single cycle wide;
- a channel changes source only right after one of its own output ticks.

The exact periods are shown only by the bench scenarios, which measure tick intervals: 32 and 64 cycles at the two rates, and the normal periods on the other channel. The scenarios also show the boundary behaviour when switching with a silent normal source. One pending reference tick still appears after the override is cleared. A set override waits indefinitely until the normal source ticks. The one long interval after a rate flag flip also appears only in the scenarios.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;
  localparam int unsigned NUM_CH_DEF = 2;
  localparam int unsigned DIV_DEF    = 16;

  typedef enum logic {
    SRC_NORM = 1'b0,
    SRC_REF  = 1'b1
  } src_e;
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsel_ctrl_reg.sv
module bsel_ctrl_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CH   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] ovr_en
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;

  logic              hit;
  logic              wr_en;
  logic              rd_en;
  logic [NUM_CH-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign hit   = bus_sel && (bus_addr == REG_ADDR);
  assign wr_en = hit && bus_we;
  assign rd_en = hit && !bus_we;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = bus_wdata[NUM_CH-1:0];
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en) rdata_d = {{PAD_W{1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign ovr_en    = ctrl_q;
endmodule

// File: rtl/bsel_ref_div.sv
module bsel_ref_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  output logic fast_tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fast_q, fast_d;

  always_comb begin
    cnt_d  = cnt_q;
    fast_d = 1'b0;
    if (ref_tick) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        fast_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
    end
  end

  assign fast_tick = fast_q;
endmodule

// File: rtl/bsel_chan.sv
module bsel_chan
  import baud_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic norm_tick,
  input  logic ovr_en,
  input  logic dbl_rate,
  output logic baud_tick,
  output logic on_ref
);
  src_e src_q, src_d;
  logic dbl_q, dbl_d;
  logic half_q, half_d;
  logic rate_tick;
  logic out_tick;

  assign rate_tick = dbl_q ? fast_tick : (fast_tick && half_q);
  assign out_tick  = (src_q == SRC_REF) ? rate_tick : norm_tick;

  always_comb begin
    half_d = half_q;
    src_d  = src_q;
    dbl_d  = dbl_q;
    if (fast_tick) half_d = !half_q;
    if (out_tick) begin
      src_d = ovr_en ? SRC_REF : SRC_NORM;
      dbl_d = dbl_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NORM;
      dbl_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      dbl_q  <= dbl_d;
      half_q <= half_d;
    end
  end

  assign baud_tick = out_tick;
  assign on_ref    = (src_q == SRC_REF);
endmodule

// File: rtl/dual_baud_sel.sv
module dual_baud_sel
  import baud_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned DIV      = DIV_DEF,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  input  logic [NUM_CH-1:0] dbl_rate,
  input  logic [NUM_CH-1:0] norm_tick,
  output logic [NUM_CH-1:0] baud_tick
);
  logic              rst_sync_n;
  logic [NUM_CH-1:0] ovr_en;
  logic [NUM_CH-1:0] on_ref;
  logic              fast_tick;

  bsel_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsel_ctrl_reg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .REG_ADDR (REG_ADDR)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ovr_en    (ovr_en)
  );

  bsel_ref_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ref_tick  (ref_tick),
    .fast_tick (fast_tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    bsel_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .fast_tick (fast_tick),
      .norm_tick (norm_tick[i]),
      .ovr_en    (ovr_en[i]),
      .dbl_rate  (dbl_rate[i]),
      .baud_tick (baud_tick[i]),
      .on_ref    (on_ref[i])
    );
  end
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned DIV      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h9F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ref_tick,
  input logic              fast_tick,
  input logic [NUM_CH-1:0] ctrl,
  input logic [NUM_CH-1:0] on_ref,
  input logic [NUM_CH-1:0] baud_tick
);
  localparam int unsigned PW = $clog2(DIV + 2);

  logic          wr_hit;
  logic [PW-1:0] pulse_q;

  assign wr_hit = bus_sel && bus_we && (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_q <= '0;
    else if (fast_tick) pulse_q <= PW'(ref_tick);
    else if (ref_tick)  pulse_q <= pulse_q + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctrl == '0 && on_ref == '0)); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> (ctrl == $past(ctrl))); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_CH] == '0); // R2

  AST_FAST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fast_tick |-> (pulse_q == PW'(DIV))); // R4

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PW'(DIV)); // R4

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_REF_ON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (on_ref[i] && baud_tick[i]) |-> fast_tick); // R5

    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (on_ref[i] && baud_tick[i]) |=> !(on_ref[i] && baud_tick[i])); // R9

    AST_SWITCH_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (on_ref[i] != $past(on_ref[i])) |-> $past(baud_tick[i])); // R8
  end
endmodule

bind dual_baud_sel bsel_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_CH   (NUM_CH),
  .DIV      (DIV),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ref_tick  (ref_tick),
  .fast_tick (fast_tick),
  .ctrl      (ovr_en),
  .on_ref    (on_ref),
  .baud_tick (baud_tick)
);

// File: tb/tb_dual_baud_sel.sv
module tb_dual_baud_sel;
  localparam logic [7:0] ADDR = 8'h9F;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       ref_tick;
  logic [1:0] dbl_rate, norm_tick, baud_tick;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  int norm_per[2];
  bit norm_man[2];
  int tcount[2];
  int last_t[2];
  bit have_last[2];
  int wide_cnt;
  int ncyc = 0;
  int exp_q0[$];
  int exp_q1[$];

  always #5 clk = ~clk;

  dual_baud_sel dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .dbl_rate(dbl_rate), .norm_tick(norm_tick),
    .baud_tick(baud_tick)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference enable: one pulse every second cycle once out of reset
  initial begin
    ref_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      ref_tick = rst_n ? ~ref_tick : 1'b0;
    end
  end

  // normal tick sources
  initial begin
    int cnt[2];
    cnt[0] = 0; cnt[1] = 0;
    norm_tick = '0;
    forever begin
      @(posedge clk); #1;
      for (int c = 0; c < 2; c++) begin
        logic t;
        t = 1'b0;
        if (norm_per[c] != 0) begin
          cnt[c]++;
          if (cnt[c] >= norm_per[c]) begin
            cnt[c] = 0;
            t = 1'b1;
          end
        end
        norm_tick[c] = t | norm_man[c];
      end
    end
  end

  // monitor: measures tick intervals and pops expected intervals
  initial begin
    logic [1:0] prev;
    prev = '0;
    forever begin
      @(negedge clk);
      ncyc++;
      for (int c = 0; c < 2; c++) begin
        if (baud_tick[c] && prev[c]) wide_cnt++;
        if (baud_tick[c]) begin
          tcount[c]++;
          if (have_last[c]) begin
            if (c == 0 && exp_q0.size() > 0)
              chk("R5/R7/R8", "ch0 tick interval", ncyc - last_t[c], exp_q0.pop_front());
            else if (c == 1 && exp_q1.size() > 0)
              chk("R5/R7/R8", "ch1 tick interval", ncyc - last_t[c], exp_q1.pop_front());
          end
          last_t[c] = ncyc;
          have_last[c] = 1'b1;
        end
      end
      prev = baud_tick;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string req, input int exp);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    @(negedge clk);
    chk(req, "register read", int'(bus_rdata), exp);
  endtask

  task automatic wait_ticks(input int c, input int n);
    int start;
    start = tcount[c];
    while (tcount[c] < start + n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q0.size() > 0 || exp_q1.size() > 0) @(negedge clk);
  endtask

  task automatic pass_window(input string req);
    int bad;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (baud_tick !== norm_tick) bad++;
    end
    chk(req, "normal pass-through mismatches", bad, 0);
  endtask

  task automatic count_window(input int c, input int cycles, output int n);
    int start;
    start = tcount[c];
    repeat (cycles) @(negedge clk);
    n = tcount[c] - start;
  endtask

  initial begin
    #(10 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    dbl_rate = '0;
    norm_per[0] = 5; norm_per[1] = 7;
    norm_man[0] = 1'b0; norm_man[1] = 1'b0;
    wide_cnt = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3: reset state
    bus_rd(ADDR, "R3", 0);
    pass_window("R3");

    // R1: other address ignored; R2: other address reads zero
    bus_wr(ADDR + 8'h1, 8'hFF);
    bus_rd(ADDR, "R1", 0);
    bus_rd(ADDR + 8'h1, "R2", 0);

    // R2: reserved bits dropped; ch0 fast override, ch1 stays normal (R7)
    dbl_rate = 2'b01;
    bus_wr(ADDR, 8'hFD);
    bus_rd(ADDR, "R2", 1);
    wait_ticks(0, 3);
    wait_ticks(1, 2);
    repeat (3) exp_q0.push_back(32);
    repeat (4) exp_q1.push_back(7);
    drain();

    // R1/R5: both on, ch1 at the low rate
    bus_wr(ADDR, 8'h03);
    bus_rd(ADDR, "R1", 3);
    wait_ticks(1, 3);
    repeat (3) exp_q1.push_back(64);
    drain();

    // R8: rate flag flip waits for the next slow tick
    wait_ticks(1, 1);
    @(posedge clk); #1 dbl_rate = 2'b11;
    exp_q1.push_back(64);
    exp_q1.push_back(32);
    exp_q1.push_back(32);
    drain();

    // R8: clearing the override with a silent normal source: one pending reference tick
    norm_per[0] = 0;
    bus_wr(ADDR, 8'h02);
    count_window(0, 150, n);
    chk("R8", "ticks after override cleared", n, 1);

    // R8: setting the override waits for a normal tick
    bus_wr(ADDR, 8'h03);
    count_window(0, 150, n);
    chk("R8", "ticks while waiting for normal tick", n, 0);
    @(negedge clk); norm_man[0] = 1'b1;
    @(negedge clk); norm_man[0] = 1'b0;
    wait_ticks(0, 3);
    // R4: sixteen reference pulses (two cycles apart) per fast tick
    repeat (2) exp_q0.push_back(32);
    drain();

    // R9: reference ticks single-cycle
    chk("R9", "multi-cycle ticks seen", wide_cnt, 0);

    // R6: back to normal sources
    norm_per[0] = 4;
    bus_wr(ADDR, 8'h00);
    wait_ticks(0, 3);
    wait_ticks(1, 3);
    pass_window("R6");
    bus_rd(ADDR, "R1", 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule